// File: doc/BRIEF.md
# Loadable Shift Register with Clock Inhibit

This block is an eight-stage register that either captures a parallel word or moves its contents one stage per clock toward a single serial output. A level on the mode pin chooses between the two operations. A separate inhibit pin freezes the register. All of this happens on one free-running clock, with inhibit acting as a synchronous enable rather than a gate on the clock net.

An active-low clear empties every stage at once, with no clock edge needed, and overrides every other input. Its release passes through a short synchronizer, so the register starts working again a fixed number of edges after clear goes high.

The serial output is the last stage. After a load, the word leaves most significant position first. Every stage is also brought out on a debug bus.

Top module: `load_shift_reg`

## Requirements
- R1: While `rst_ni` is low, all eight stages and `ser_o` read 0, immediately and without any clock edge, whatever the other inputs are.
- R2: With `rst_ni` high, `inhibit_i` low and `shift_i` low, a rising clock edge copies `par_i[k]` into stage k for every k, so that `stages_o` equals `par_i`.
- R3: With `rst_ni` high, `inhibit_i` low and `shift_i` high, a rising edge moves stage k-1 into stage k for k = 1 to 7 and puts `ser_i` into stage 0, so the new `stages_o` is {old `stages_o[6:0]`, `ser_i`}.
- R4: With `inhibit_i` high, a rising edge leaves every stage unchanged, whatever `shift_i`, `ser_i` and `par_i` are.
- R5: After `rst_ni` rises, the first two rising edges leave the register at 0. The third edge is the first to act.
- R6: `ser_o` always shows stage 7. After a load, `ser_o` presents `par_i[7]`, then `par_i[6]`, and so on down to `par_i[0]`, moving one position per shift edge.
- R7: A change on `par_i` between clock edges does not alter `stages_o`. A load takes effect only at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock; all state changes happen on its rising edge |
| rst_ni | input | 1 | Active-low clear: asserts asynchronously, releases synchronously |
| shift_i | input | 1 | Mode select: 1 = shift, 0 = parallel load |
| inhibit_i | input | 1 | 1 = hold all stages on clock edges |
| ser_i | input | 1 | Serial data entering stage 0 |
| par_i | input | 8 | Parallel word; bit k goes to stage k |
| ser_o | output | 1 | Serial output, equal to stage 7 |
| stages_o | output | 8 | Debug view of all stages; bit k is stage k |

## Verification
The bound checker watches the per-edge rules on every cycle:
- a load captures the word sampled at that edge;
- a shift moves the stages and brings in the serial bit;
- inhibit holds the register stable;
- the register stays empty while the clear release is still in the synchronizer;
- the serial output follows the previous stage after a shift.

Several behaviours only the bench's scenarios can show:
- the clear acts before any edge arrives;
- a word changing between edges leaves the register untouched;
- the third edge after release is the first to act;
- a loaded word leaves the serial pin in the stated bit order across eight shifts.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  localparam int unsigned LSR_WIDTH = 8;
  localparam int unsigned LSR_SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_SHIFT = 2'd2
  } lsr_op_e;

  function automatic lsr_op_e lsr_decode(input logic shift_sel, input logic inhibit);
    if (inhibit) return OP_HOLD;
    else if (shift_sel) return OP_SHIFT;
    else return OP_LOAD;
  endfunction
endpackage

// File: rtl/lsr_rst_sync.sv
module lsr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/lsr_op_decode.sv
module lsr_op_decode
  import lsr_pkg::*;
(
  input  logic    shift_i,
  input  logic    inhibit_i,
  output lsr_op_e op_o
);
  always_comb op_o = lsr_decode(shift_i, inhibit_i);
endmodule

// File: rtl/lsr_stage_bank.sv
module lsr_stage_bank
  import lsr_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  lsr_op_e          op_i,
  input  logic             ser_i,
  input  logic [WIDTH-1:0] par_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar k = 0; k < WIDTH; k++) begin : g_stage
    logic shift_src;
    logic bit_q;

    if (k == 0) begin : g_head
      assign shift_src = ser_i;
    end else begin : g_body
      assign shift_src = q_o[k-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bit_q <= 1'b0;
      end else begin
        unique case (op_i)
          OP_LOAD:  bit_q <= par_i[k];
          OP_SHIFT: bit_q <= shift_src;
          default:  bit_q <= bit_q;
        endcase
      end
    end

    assign q_o[k] = bit_q;
  end
endmodule

// File: rtl/load_shift_reg.sv
module load_shift_reg
  import lsr_pkg::*;
#(
  parameter int unsigned WIDTH       = LSR_WIDTH,
  parameter int unsigned SYNC_STAGES = LSR_SYNC_STAGES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic             inhibit_i,
  input  logic             ser_i,
  input  logic [WIDTH-1:0] par_i,
  output logic             ser_o,
  output logic [WIDTH-1:0] stages_o
);
  localparam int unsigned LAST = WIDTH - 1;

  logic    rst_rel_n;
  lsr_op_e op;

  // assert is async via rst_ni, release aligned to clk_i
  lsr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_rel_n)
  );

  lsr_op_decode u_decode (
    .shift_i   (shift_i),
    .inhibit_i (inhibit_i),
    .op_o      (op)
  );

  lsr_stage_bank #(.WIDTH(WIDTH)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_rel_n),
    .op_i   (op),
    .ser_i  (ser_i),
    .par_i  (par_i),
    .q_o    (stages_o)
  );

  assign ser_o = stages_o[LAST];
endmodule

// File: rtl/load_shift_reg_chk.sv
module load_shift_reg_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rst_rel_n,
  input logic             shift_i,
  input logic             inhibit_i,
  input logic             ser_i,
  input logic [WIDTH-1:0] par_i,
  input logic             ser_o,
  input logic [WIDTH-1:0] stages_o
);
  p_clear_empty_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (stages_o == '0 && !ser_o));

  p_load_word_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_rel_n && !inhibit_i && !shift_i) |=> stages_o == $past(par_i));

  p_shift_move_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_rel_n && !inhibit_i && shift_i)
      |=> stages_o == {$past(stages_o[WIDTH-2:0]), $past(ser_i)});

  p_inhibit_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_rel_n && inhibit_i) |=> $stable(stages_o));

  p_release_wait_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_rel_n |-> stages_o == '0);

  p_serial_follow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_rel_n && !inhibit_i && shift_i) |=> ser_o == $past(stages_o[WIDTH-2]));
endmodule

bind load_shift_reg load_shift_reg_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rst_rel_n (rst_rel_n),
  .shift_i   (shift_i),
  .inhibit_i (inhibit_i),
  .ser_i     (ser_i),
  .par_i     (par_i),
  .ser_o     (ser_o),
  .stages_o  (stages_o)
);

// File: tb/load_shift_reg_bench.sv
module load_shift_reg_bench;
  localparam int NVEC = 14;
  // {shift, inhibit, ser, par[7:0], expected stages[7:0]}
  localparam logic [18:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 1'b0, 8'hA5, 8'hA5},
    {1'b1, 1'b0, 1'b0, 8'h00, 8'h4A},
    {1'b1, 1'b0, 1'b1, 8'h00, 8'h95},
    {1'b0, 1'b1, 1'b0, 8'hFF, 8'h95},
    {1'b1, 1'b1, 1'b1, 8'h00, 8'h95},
    {1'b1, 1'b0, 1'b1, 8'h00, 8'h2B},
    {1'b1, 1'b0, 1'b0, 8'h00, 8'h56},
    {1'b0, 1'b0, 1'b0, 8'h3C, 8'h3C},
    {1'b1, 1'b0, 1'b1, 8'h00, 8'h79},
    {1'b1, 1'b0, 1'b1, 8'h00, 8'hF3},
    {1'b1, 1'b0, 1'b0, 8'h00, 8'hE6},
    {1'b1, 1'b1, 1'b0, 8'h00, 8'hE6},
    {1'b1, 1'b0, 1'b0, 8'h00, 8'hCC},
    {1'b0, 1'b0, 1'b0, 8'h00, 8'h00}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       shift_sel = 1'b0;
  logic       inhibit = 1'b1;
  logic       ser_in = 1'b0;
  logic [7:0] par = 8'h00;
  logic       ser_out;
  logic [7:0] stages;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  load_shift_reg u_load_shift_reg (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .shift_i   (shift_sel),
    .inhibit_i (inhibit),
    .ser_i     (ser_in),
    .par_i     (par),
    .ser_o     (ser_out),
    .stages_o  (stages)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic edge_step();
    @(posedge clk);
    #1;
  endtask

  task automatic drive(input logic s, input logic inh, input logic d, input logic [7:0] p);
    shift_sel = s;
    inhibit = inh;
    ser_in = d;
    par = p;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    #1;
    check("R1 reset stages", stages, 8'h00);
    check("R1 reset ser_o", {7'd0, ser_out}, 8'h00);
    edge_step();
    edge_step();

    // release with a pending load of FF
    rst_n = 1'b1;
    drive(1'b0, 1'b0, 1'b0, 8'hFF);
    edge_step();
    check("R5 edge 1 after release", stages, 8'h00);
    edge_step();
    check("R5 edge 2 after release", stages, 8'h00);
    edge_step();
    check("R5 edge 3 acts", stages, 8'hFF);

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][18], VEC[i][17], VEC[i][16], VEC[i][15:8]);
      edge_step();
      if (VEC[i][17]) check("R4 inhibit hold", stages, VEC[i][7:0]);
      else if (VEC[i][18]) check("R3 shift", stages, VEC[i][7:0]);
      else check("R2 load", stages, VEC[i][7:0]);
      check("R6 ser_o is stage 7", {7'd0, ser_out}, {7'd0, VEC[i][7]});
    end

    // a new word between edges does nothing until the edge
    drive(1'b0, 1'b0, 1'b0, 8'h5A);
    #1;
    check("R7 no change before edge", stages, 8'h00);
    par = 8'hC3;
    edge_step();
    check("R7 word at edge loaded", stages, 8'hC3);

    // load then eight shifts, serial order check
    drive(1'b0, 1'b0, 1'b0, 8'h96);
    edge_step();
    check("R2 load 96", stages, 8'h96);
    for (int k = 0; k < 8; k++) begin
      check("R6 serial order", {7'd0, ser_out}, {7'd0, 8'h96 >> (7 - k)} & 8'h01);
      drive(1'b1, 1'b0, 1'b0, 8'hFF);
      edge_step();
    end
    check("R3 emptied after eight shifts", stages, 8'h00);

    // clear asserted while shifting
    drive(1'b0, 1'b0, 1'b0, 8'hFF);
    edge_step();
    drive(1'b1, 1'b0, 1'b1, 8'h00);
    edge_step();
    check("R3 shift before clear", stages, 8'hFF);
    rst_n = 1'b0;
    #1;
    check("R1 clear without edge", stages, 8'h00);
    edge_step();
    check("R1 clear overrides shift", stages, 8'h00);
    rst_n = 1'b1;
    edge_step();
    check("R5 held edge 1", stages, 8'h00);
    edge_step();
    check("R5 held edge 2", stages, 8'h00);
    edge_step();
    check("R5 first shift after release", stages, 8'h01);

    finished = 1'b1;
    summary();
  end
endmodule